// File: doc/BRIEF.md
# Serial Transceiver with Selectable Ninth Bit

This block is a register-mapped asynchronous serial transmitter and receiver for a processor bus. Software programs a 16-bit divisor T, written as a low byte and a high byte, and the bit time becomes 2*(T+2) clock cycles. For example, T=0x0567 with a 26.601712 MHz clock gives 9600 baud. Each frame carries eight data bits, least significant first. A control bit can add a ninth bit, so a frame is either 10 or 11 bit times long.

Writing the transmit data register starts a frame on `txd`. The receiver watches `rxd` for a falling edge and checks the start bit at its midpoint. It then samples every following bit at its midpoint and hands the byte and the optional ninth bit to software. A status register gathers the receive and transmit flags. It also reflects two static video-standard selector pins, so software can read them in the same byte.

Register map, selected by `bus_addr`:
- 0: divisor low byte (write).
- 1: divisor high byte (write).
- 2: control on write, status on read.
- 3: transmit data on write, received data on read.

Top module: `sercom_core`

## Requirements
- R1: The bit time is exactly 2*(T+2) clock cycles. T has its bits 7..0 written at address 0 and its bits 15..8 written at address 1, and resets to 0.
- R2: `txd` is 1 when no frame is being sent. A frame begins with a 0 start bit and sends the data bits least significant first. When control bit 5 is 0, the frame has 10 bits: start, 8 data, and a 1 stop bit.
- R3: When control bit 5 is 1, the frame has 11 bits. Control bit 0 is sent as the ninth bit, between data bit 7 and the stop bit.
- R4: A write to address 3 starts a frame on the next clock edge and clears status bit 6 (transmit complete). Status bit 6 becomes 1 exactly 11*2*(T+2) or 10*2*(T+2) cycles after that edge, once the stop bit time has ended.
- R5: For a received frame, a read of address 3 returns the eight data bits and status bit 7 (receive complete) is set. Status bit 0 holds the received ninth bit in 11-bit mode and reads 0 in 10-bit mode. The frame length follows control bit 5 as it was when the start edge arrived.
- R6: A stop bit sampled as 0 sets status bit 1 (receive error). The byte is still delivered and status bit 7 is still set.
- R7: A read of address 3 (`bus_rd` high) clears status bits 7 and 1.
- R8: Status bit 5 (receive busy) is 1 while the receiver is inside a frame, from start-edge detection until the stop-bit sample.
- R9: A low pulse on `rxd` that has ended by the start-bit midpoint is discarded. Afterwards status bit 5 is 0 and status bit 7 stays 0.
- R10: Status bit 4 reads `std_sel_hi`, status bit 3 reads `std_sel_lo`, and status bit 2 reads 0.
- R11: After reset, `txd` is 1 and status bits 7, 6, 5, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe (has a side effect only at address 3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| std_sel_hi | input | 1 | Video-standard selector pin shown in status bit 4 |
| std_sel_lo | input | 1 | Video-standard selector pin shown in status bit 3 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The transmit path is looped back to the receiver for six frames. These frames mix divisors, including 0, 1 and one with a nonzero high byte. They use both frame lengths, both ninth-bit values, and the data patterns all-zeros, all-ones, alternating, and edge-bit-only. The divisor mix separates a wrong bit-time formula from a wrong byte assembly. The line is sampled mid-bit, which exposes bit-order or ninth-bit placement faults. Frames sent with the ninth bit disabled but a 1 in control bit 0 show whether that bit leaks into short frames. Hand-driven frames cover the cases loopback cannot produce: a bad stop bit, and a too-short start pulse.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_DIV_LO    = 2'd0,
        REG_DIV_HI    = 2'd1,
        REG_CTRL_STAT = 2'd2,
        REG_DATA      = 2'd3
    } reg_sel_e;

    localparam int CTRL_B9_BIT  = 0;
    localparam int CTRL_LEN_BIT = 5;

    localparam int ST_RX9    = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_STD_LO = 3;
    localparam int ST_STD_HI = 4;
    localparam int ST_RXBUSY = 5;
    localparam int ST_TXDONE = 6;
    localparam int ST_RXDONE = 7;
endpackage

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  full_lim,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    input  logic              en9,
    input  logic              b9,
    output logic              txd,
    output logic              done
);
    localparam int FR_W = BYTE_W + 3;

    typedef struct packed {
        logic             busy;
        logic [FR_W-1:0]  sh;
        logic [3:0]       left;
        logic [CNT_W-1:0] cnt;
    } tx_st_t;

    tx_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.sh   = en9 ? {1'b1, b9, data, 1'b0} : {2'b11, data, 1'b0};
            st_d.left = en9 ? 4'd11 : 4'd10;
        end else if (st_q.busy) begin
            if (st_q.cnt == full_lim) begin
                st_d.cnt  = '0;
                st_d.sh   = {1'b1, st_q.sh[FR_W-1:1]};
                st_d.left = st_q.left - 4'd1;
                if (st_q.left == 4'd1) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign txd = st_q.busy ? st_q.sh[0] : 1'b1;

    a_r1_tx_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.cnt <= full_lim);
    a_r3_tx_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= 4'd11);
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  half_lim,
    input  logic [CNT_W-1:0]  full_lim,
    input  logic              en9,
    input  logic              rxd,
    output logic              busy,
    output logic              done,
    output logic              ferr,
    output logic [BYTE_W-1:0] data,
    output logic              nine
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              prev;
        logic              busy;
        logic              first;
        logic              en9;
        logic [3:0]        idx;
        logic [BYTE_W:0]   sh;
        logic [CNT_W-1:0]  cnt;
    } rx_st_t;

    rx_st_t st_q, st_d;
    logic   bit_now;
    logic   at_lim;

    always_comb begin
        st_d      = st_q;
        done      = 1'b0;
        bit_now   = st_q.s2;
        at_lim    = st_q.first ? (st_q.cnt == half_lim) : (st_q.cnt == full_lim);
        st_d.s1   = rxd;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (!st_q.busy) begin
            if (st_q.prev && !st_q.s2) begin
                st_d.busy  = 1'b1;
                st_d.first = 1'b1;
                st_d.cnt   = '0;
                st_d.idx   = '0;
                st_d.en9   = en9;
            end
        end else if (at_lim) begin
            st_d.cnt = '0;
            if (st_q.first) begin
                if (bit_now) st_d.busy  = 1'b0;
                else         st_d.first = 1'b0;
            end else if (st_q.idx < (st_q.en9 ? 4'd9 : 4'd8)) begin
                st_d.sh  = {bit_now, st_q.sh[BYTE_W:1]};
                st_d.idx = st_q.idx + 4'd1;
            end else begin
                done      = 1'b1;
                st_d.busy = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.s1   <= 1'b1;
            st_q.s2   <= 1'b1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign ferr = ~bit_now;
    assign data = st_q.en9 ? st_q.sh[BYTE_W-1:0] : st_q.sh[BYTE_W:1];
    assign nine = st_q.en9 & st_q.sh[BYTE_W];

    a_r8_rx_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.cnt <= full_lim);
    a_r5_rx_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= 4'd9);
endmodule

// File: rtl/sercom_core.sv
module sercom_core
    import sercom_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              std_sel_hi,
    input  logic              std_sel_lo,
    input  logic              rxd,
    output logic              txd
);
    localparam int CNT_W = DIV_W + 2;
    localparam int HI_W  = DIV_W - BYTE_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              en9;
        logic              b9;
        logic              tc;
        logic              rc;
        logic              err;
        logic              rx9;
        logic [BYTE_W-1:0] rxb;
    } core_st_t;

    core_st_t st_q, st_d;

    logic [CNT_W-1:0]  half_lim, full_lim;
    logic              tx_start, tx_done;
    logic              rx_busy, rx_done, rx_ferr, rx_nine;
    logic [BYTE_W-1:0] rx_data;
    logic              data_rd;

    assign half_lim = {2'b00, st_q.div} + CNT_W'(1);
    assign full_lim = {1'b0, st_q.div, 1'b1} + CNT_W'(2);
    assign tx_start = bus_wr && (bus_addr == REG_DATA);
    assign data_rd  = bus_rd && (bus_addr == REG_DATA);

    sercom_tx #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_lim (full_lim),
        .start    (tx_start),
        .data     (bus_wdata),
        .en9      (st_q.en9),
        .b9       (st_q.b9),
        .txd      (txd),
        .done     (tx_done)
    );

    sercom_rx #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_lim (half_lim),
        .full_lim (full_lim),
        .en9      (st_q.en9),
        .rxd      (rxd),
        .busy     (rx_busy),
        .done     (rx_done),
        .ferr     (rx_ferr),
        .data     (rx_data),
        .nine     (rx_nine)
    );

    always_comb begin
        st_d = st_q;
        if (tx_done) st_d.tc = 1'b1;
        if (bus_wr) begin
            case (bus_addr)
                REG_DIV_LO:    st_d.div[BYTE_W-1:0]     = bus_wdata;
                REG_DIV_HI:    st_d.div[DIV_W-1:BYTE_W] = bus_wdata[HI_W-1:0];
                REG_CTRL_STAT: begin
                    st_d.en9 = bus_wdata[CTRL_LEN_BIT];
                    st_d.b9  = bus_wdata[CTRL_B9_BIT];
                end
                default:       st_d.tc = 1'b0;
            endcase
        end
        if (data_rd) begin
            st_d.rc  = 1'b0;
            st_d.err = 1'b0;
        end
        if (rx_done) begin
            st_d.rc  = 1'b1;
            st_d.err = st_d.err | rx_ferr;
            st_d.rxb = rx_data;
            st_d.rx9 = rx_nine;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL_STAT: begin
                bus_rdata[ST_RXDONE] = st_q.rc;
                bus_rdata[ST_TXDONE] = st_q.tc;
                bus_rdata[ST_RXBUSY] = rx_busy;
                bus_rdata[ST_STD_HI] = std_sel_hi;
                bus_rdata[ST_STD_LO] = std_sel_lo;
                bus_rdata[ST_ERR]    = st_q.err;
                bus_rdata[ST_RX9]    = st_q.rx9;
            end
            REG_DATA: bus_rdata = st_q.rxb;
            default:  bus_rdata = '0;
        endcase
    end

    a_r4_tc_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !st_q.tc);
    a_r4_line_high_on_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tc) |-> txd);
    a_r6_bad_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ferr) |=> (st_q.err && st_q.rc));
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_done) |=> (!st_q.rc && !st_q.err));
endmodule

// File: tb/sercom_core_bench.sv
module sercom_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       std_sel_hi = 1'b1;
    logic       std_sel_lo = 1'b0;
    logic       loop_sel = 1'b1;
    logic       line = 1'b1;
    logic       txd;
    logic       rxd;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    assign rxd = loop_sel ? txd : line;

    always #5 clk = ~clk;

    sercom_core u_sercom_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .std_sel_hi (std_sel_hi),
        .std_sel_lo (std_sel_lo),
        .rxd        (rxd),
        .txd        (txd)
    );

    // vector: {divisor[15:0], len9, ninth, data[7:0]}
    localparam logic [25:0] VEC [6] = '{
        {16'h0003, 1'b0, 1'b0, 8'hA5},
        {16'h0000, 1'b1, 1'b1, 8'h3C},
        {16'h0007, 1'b1, 1'b0, 8'hFF},
        {16'h0001, 1'b0, 1'b1, 8'h00},
        {16'h0005, 1'b1, 1'b1, 8'h81},
        {16'h0102, 1'b0, 1'b0, 8'h5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_status(output logic [7:0] s);
        bus_addr = 2'd2;
        #1 s = bus_rdata;
    endtask

    task automatic rd_data(output logic [7:0] d);
        @(negedge clk);
        bus_addr = 2'd3; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drive_bit(input logic b, input int bp);
        line = b;
        repeat (bp) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R10 pin mirror
        chk("R11 txd idle after reset", 32'(txd), 32'd1);
        rd_status(s);
        chk("R11 status flags after reset", 32'(s & 8'hE3), 32'h0);
        chk("R10 pins in bits 4,3 and bit 2 zero", 32'(s & 8'h1C), 32'h10);
        std_sel_hi = 1'b0; std_sel_lo = 1'b1;
        rd_status(s);
        chk("R10 pins swapped", 32'(s & 8'h1C), 32'h08);

        // Table walk: loopback frames, R1 R2 R3 R4 R5 R7
        for (int v = 0; v < 6; v++) begin
            logic [15:0] t;
            logic        l9, b9;
            logic [7:0]  dat;
            logic [10:0] fr;
            int          bp, nb;
            {t, l9, b9, dat} = VEC[v];
            bp = 2 * (int'(t) + 2);
            nb = l9 ? 11 : 10;
            fr = l9 ? {1'b1, b9, dat, 1'b0} : {2'b11, dat, 1'b0};
            wr(2'd0, t[7:0]);
            wr(2'd1, t[15:8]);
            wr(2'd2, {2'b00, l9, 4'b0000, b9});
            wr(2'd3, dat);
            rd_status(s);
            chk("R4 complete flag cleared by write", 32'(s[6]), 32'd0);
            repeat (bp / 2) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
                chk(l9 ? "R3 frame bit mid-sample" : "R2 frame bit mid-sample",
                    32'(txd), 32'(fr[i]));
                if (i < nb - 1) repeat (bp) @(negedge clk);
            end
            repeat (bp / 2 - 1) @(negedge clk);
            rd_status(s);
            chk("R1 R4 not complete one cycle early", 32'(s[6]), 32'd0);
            @(negedge clk);
            rd_status(s);
            chk("R1 R4 complete after full frame", 32'(s[6]), 32'd1);
            chk("R2 line idle after frame", 32'(txd), 32'd1);
            repeat (bp) @(negedge clk);
            rd_status(s);
            chk("R5 receive complete set", 32'(s[7]), 32'd1);
            chk("R5 ninth bit status", 32'(s[0]), 32'(l9 & b9));
            rd_data(d);
            chk("R5 received byte", 32'(d), 32'(dat));
            rd_status(s);
            chk("R7 read clears receive complete", 32'(s[7]), 32'd0);
        end

        // R6 R8 R7: hand-driven frame with a low stop bit, divisor 3
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h00);
        loop_sel = 1'b0;
        line = 1'b1;
        repeat (4) @(negedge clk);
        line = 1'b0;
        repeat (4) @(negedge clk);
        rd_status(s);
        chk("R8 busy after start edge", 32'(s[5]), 32'd1);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 8; i++) drive_bit(((8'h5A >> i) & 8'h01) != 0, 10);
        drive_bit(1'b0, 10);
        line = 1'b1;
        repeat (20) @(negedge clk);
        rd_status(s);
        chk("R6 error flag on low stop", 32'(s[1]), 32'd1);
        chk("R6 complete flag on low stop", 32'(s[7]), 32'd1);
        chk("R8 busy dropped after stop", 32'(s[5]), 32'd0);
        rd_data(d);
        chk("R6 byte delivered despite error", 32'(d), 32'h5A);
        rd_status(s);
        chk("R7 read clears error and complete", 32'(s & 8'h82), 32'h0);

        // R9 false start: one-cycle low pulse
        line = 1'b0;
        @(negedge clk);
        line = 1'b1;
        repeat (30) @(negedge clk);
        rd_status(s);
        chk("R9 short pulse leaves receiver idle", 32'(s[5]), 32'd0);
        chk("R9 short pulse gives no byte", 32'(s[7]), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule